// File: doc/BRIEF.md
# PS/2 host receive engine

This block turns the PS/2 clock and data lines, as seen by a host, into received bytes. Both pad inputs are asynchronous, so they first pass through synchronizer flops. The data line is sampled on each falling clock edge, because the device changes data while the clock is high. Eleven samples make a frame: a low start bit, eight data bits sent least significant bit first, an odd parity bit and a high stop bit. A completed byte is placed in a one-entry output slot with a valid/ready handshake.

A free-running microsecond tick gives the time of each falling edge. An edge that comes too soon after the last accepted edge is treated as a glitch and ignored. An edge that comes too soon after the companion transmitter reports a finished transfer is also ignored. If no edge arrives within the maximum interval while a frame is in progress, the frame is aborted as a missed edge. Every framing fault clears the partial frame and sends a one-cycle request to the companion transmitter to send the resend command. The command byte itself is an output of the block. A configuration input tells the block whether the host transmit path is in use. When it is off, parity faults are fatal, acknowledge codes are dropped and not-acknowledge codes are treated as faults. When it is on, all three kinds of byte are delivered.

The output slot applies back-pressure as follows. While `rx_valid` is high and `rx_ready` is low, the slot holds its contents unchanged. The link itself cannot be stalled. So a byte that completes while the slot is still full and not being taken is discarded, and a resend is requested. A byte that completes in the same cycle as the consumer takes the slot goes into the slot.

Top module: `ps2_host_rx`

## Requirements
- R1: Each accepted falling edge samples the data line. Frame index 0 is the start bit, indices 1 to 8 are data bits least significant first, index 9 is parity and index 10 is stop. A frame with a low start bit, correct odd parity (parity bit equal to the inverted XOR of the eight data bits) and a high stop bit delivers its byte with `rx_valid` high and `rx_parity_err` low.
- R2: A high start bit at index 0 aborts the frame, delivers nothing and raises `resend_req`.
- R3: A low stop bit at index 10 aborts the frame, delivers nothing and raises `resend_req`.
- R4: With `wr_en_cfg` low, a parity fault at index 9 aborts the frame and raises `resend_req`. With `wr_en_cfg` high, the byte is delivered with `rx_parity_err` high.
- R5: With `wr_en_cfg` low, a received 0xFA is dropped silently (no byte, no request) and a received 0xFE aborts with `resend_req`. With `wr_en_cfg` high, both are delivered as ordinary bytes.
- R6: A falling edge less than MIN_GAP ticks (39 at the defaults) after the last accepted edge is ignored. It neither advances the frame nor restarts the interval timer.
- R7: When more than MAX_GAP ticks (120 at the defaults) pass after the last accepted edge while a frame is partly received, the frame is aborted and `resend_req` is raised. An idle gap of any length between frames raises nothing.
- R8: A falling edge less than MIN_GAP ticks after a `tx_done` pulse is ignored.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_byte` and `rx_parity_err` hold. A byte that completes then is discarded and `resend_req` is raised.
- R10: When a byte completes in the same cycle as the slot is taken (`rx_valid` and `rx_ready` high), the new byte is loaded and no request is raised.
- R11: After reset `rx_valid` and `resend_req` are low. `resend_cmd` always carries 0xFE.
- R12: `resend_req` is a single-cycle pulse for each fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ps2_clk_in | input | 1 | PS/2 clock line, asynchronous |
| ps2_dat_in | input | 1 | PS/2 data line, asynchronous |
| wr_en_cfg | input | 1 | High when the host transmit path is in use |
| tx_done | input | 1 | Pulse from the companion transmitter when a transfer ends |
| rx_valid | output | 1 | Output slot holds a byte |
| rx_ready | input | 1 | Consumer takes the byte this cycle |
| rx_byte | output | 8 | Received byte |
| rx_parity_err | output | 1 | Byte was received with a parity fault |
| resend_req | output | 1 | Pulse asking the transmitter to send `resend_cmd` |
| resend_cmd | output | 8 | Command byte for the resend request |

## Verification
Two functions can meet in one cycle: a byte completing at the stop edge, and the consumer taking the slot. The bench holds `rx_ready` low with a byte waiting, then raises `rx_ready` for exactly the one cycle in which the stop-edge byte reaches the slot. It counts that cycle from the moment the pad clock falls. The outcome is judged by two results: both bytes reach the scoreboard in order, and no resend request appears. The opposite case, where the slot stays blocked, must give one request and leave the held byte unchanged.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned FRAME_LEN  = 11;
  localparam int unsigned IDX_W      = $clog2(FRAME_LEN + 1);

  localparam logic [IDX_W-1:0] IDX_START     = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_LAST_DATA = IDX_W'(8);
  localparam logic [IDX_W-1:0] IDX_PARITY    = IDX_W'(9);
  localparam logic [IDX_W-1:0] IDX_STOP      = IDX_W'(10);

  localparam logic [BYTE_W-1:0] DEV_ACK_CODE  = 8'hFA;
  localparam logic [BYTE_W-1:0] DEV_NACK_CODE = 8'hFE;
  localparam logic [BYTE_W-1:0] HOST_RESEND   = 8'hFE;
endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ps2_tick_since.sv
module ps2_tick_since #(
  parameter int unsigned LIMIT = 121,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  // Saturating count of ticks since the last restart; resets saturated.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= LIM;
    else if (restart)            cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/ps2_frame_fsm.sv
module ps2_frame_fsm
  import ps2_rx_pkg::*;
#(
  parameter int unsigned MIN_GAP = 39,
  parameter int unsigned MAX_GAP = 120,
  parameter int unsigned GAP_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              dat,
  input  logic              tx_quiet,
  input  logic              wr_en,
  input  logic [GAP_W-1:0]  gap,
  output logic              accept,
  output logic              deliver,
  output logic              err,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_perr
);
  localparam logic [GAP_W-1:0] MIN_L = GAP_W'(MIN_GAP);
  localparam logic [GAP_W-1:0] MAX_L = GAP_W'(MAX_GAP);

  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] shreg;
  logic              perr_q;
  logic              overdue;
  logic              bad_par;

  assign overdue = (idx != IDX_START) && (gap > MAX_L);
  assign accept  = fall && tx_quiet && !overdue && (gap >= MIN_L);
  assign bad_par = ~(^shreg ^ dat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= IDX_START;
      shreg    <= '0;
      perr_q   <= 1'b0;
      deliver  <= 1'b0;
      err      <= 1'b0;
      out_byte <= '0;
      out_perr <= 1'b0;
    end else begin
      deliver <= 1'b0;
      err     <= 1'b0;
      if (overdue) begin
        idx    <= IDX_START;
        shreg  <= '0;
        perr_q <= 1'b0;
        err    <= 1'b1;
      end else if (accept) begin
        if (idx == IDX_START) begin
          if (dat) err <= 1'b1;
          else     idx <= idx + IDX_W'(1);
        end else if (idx <= IDX_LAST_DATA) begin
          shreg <= {dat, shreg[BYTE_W-1:1]};
          idx   <= idx + IDX_W'(1);
        end else if (idx == IDX_PARITY) begin
          if (bad_par && !wr_en) begin
            idx   <= IDX_START;
            shreg <= '0;
            err   <= 1'b1;
          end else begin
            perr_q <= bad_par;
            idx    <= idx + IDX_W'(1);
          end
        end else if (idx == IDX_STOP) begin
          idx    <= IDX_START;
          shreg  <= '0;
          perr_q <= 1'b0;
          if (!dat || (!wr_en && shreg == DEV_NACK_CODE)) begin
            err <= 1'b1;
          end else if (wr_en || shreg != DEV_ACK_CODE) begin
            deliver  <= 1'b1;
            out_byte <= shreg;
            out_perr <= perr_q;
          end
        end else begin
          idx    <= IDX_START;
          shreg  <= '0;
          perr_q <= 1'b0;
          err    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx
  import ps2_rx_pkg::*;
#(
  parameter int unsigned FAST_HZ     = 16700,
  parameter int unsigned SLOW_HZ     = 10000,
  parameter int unsigned SLACK_US    = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              ps2_clk_in,
  input  logic              ps2_dat_in,
  input  logic              wr_en_cfg,
  input  logic              tx_done,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_parity_err,
  output logic              resend_req,
  output logic [BYTE_W-1:0] resend_cmd
);
  localparam int unsigned MIN_GAP = 1000000 / FAST_HZ - SLACK_US;
  localparam int unsigned MAX_GAP = 1000000 / SLOW_HZ + SLACK_US;
  localparam int unsigned GAP_W   = $clog2(MAX_GAP + 2);
  localparam int unsigned QUIET_W = $clog2(MIN_GAP + 1);

  logic              clk_s, dat_s, clk_prev, fall;
  logic              accept, f_deliver, f_err, f_perr, collide, tx_quiet;
  logic [BYTE_W-1:0] f_byte;
  logic [GAP_W-1:0]  gap;
  logic [QUIET_W-1:0] quiet_cnt;

  ps2_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ps2_clk_in, ps2_dat_in}), .q({clk_s, dat_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= clk_s;
  end
  assign fall = clk_prev && !clk_s;

  ps2_tick_since #(.LIMIT(MAX_GAP + 1)) u_gap (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .restart(accept), .cnt(gap)
  );

  ps2_tick_since #(.LIMIT(MIN_GAP)) u_quiet (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .restart(tx_done), .cnt(quiet_cnt)
  );
  assign tx_quiet = (quiet_cnt == QUIET_W'(MIN_GAP));

  ps2_frame_fsm #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP), .GAP_W(GAP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .fall(fall), .dat(dat_s), .tx_quiet(tx_quiet),
    .wr_en(wr_en_cfg), .gap(gap), .accept(accept), .deliver(f_deliver),
    .err(f_err), .out_byte(f_byte), .out_perr(f_perr)
  );

  // One-entry output slot; a byte arriving into a blocked slot is lost.
  assign collide = f_deliver && rx_valid && !rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid      <= 1'b0;
      rx_byte       <= '0;
      rx_parity_err <= 1'b0;
      resend_req    <= 1'b0;
    end else begin
      resend_req <= f_err || collide;
      if (f_deliver && !collide) begin
        rx_valid      <= 1'b1;
        rx_byte       <= f_byte;
        rx_parity_err <= f_perr;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  assign resend_cmd = HOST_RESEND;
endmodule

// File: rtl/ps2_host_rx_chk.sv
module ps2_host_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_cfg,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_byte,
  input logic       rx_parity_err,
  input logic       resend_req
);
  a_r9_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_byte) && $stable(rx_parity_err)));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |=> !resend_req);

  a_r5_no_handshake_codes: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_valid) && !wr_en_cfg) |-> (rx_byte != 8'hFA && rx_byte != 8'hFE));

  a_r4_perr_needs_write_path: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_parity_err) |-> wr_en_cfg);
endmodule

bind ps2_host_rx ps2_host_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_cfg(wr_en_cfg), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_byte(rx_byte), .rx_parity_err(rx_parity_err),
  .resend_req(resend_req)
);

// File: tb/ps2_host_rx_tb.sv
`timescale 1ns/1ps
module ps2_host_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0;
  logic ps2_clk_in = 1'b1, ps2_dat_in = 1'b1;
  logic wr_en_cfg = 1'b0, tx_done = 1'b0, rx_ready = 1'b1;
  logic rx_valid, rx_parity_err, resend_req;
  logic [7:0] rx_byte, resend_cmd;

  int n_cmp = 0, n_bad = 0, exp_rs = 0, got_rs = 0;
  bit done = 1'b0, prev_rs = 1'b0;
  logic [8:0] sb[$];
  string tq[$];
  logic [8:0] exp_item;
  string exp_tag;

  always #2 clk = ~clk;

  ps2_host_rx u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ps2_clk_in(ps2_clk_in),
    .ps2_dat_in(ps2_dat_in), .wr_en_cfg(wr_en_cfg), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .rx_parity_err(rx_parity_err), .resend_req(resend_req), .resend_cmd(resend_cmd)
  );

  // Scaled microsecond: one tick every 4 clocks.
  initial forever begin
    repeat (3) @(negedge clk);
    us_tick = 1'b1;
    @(negedge clk);
    us_tick = 1'b0;
  end

  // Monitor: pops the scoreboard on every handshake, counts resend pulses.
  initial forever begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (resend_req) begin
        got_rs++;
        n_cmp++;
        if (prev_rs) begin
          n_bad++;
          $display("FAIL R12: resend_req high 2 cycles (actual 2, expected 1)");
        end
      end
      prev_rs = resend_req;
      if (rx_valid && rx_ready) begin
        n_cmp++;
        if (sb.size() == 0) begin
          n_bad++;
          $display("FAIL R1: unexpected byte actual %02h perr %0b, expected none", rx_byte, rx_parity_err);
        end else begin
          exp_item = sb.pop_front();
          exp_tag  = tq.pop_front();
          if ({rx_parity_err, rx_byte} !== exp_item) begin
            n_bad++;
            $display("FAIL %s: byte/perr actual %02h/%0b, expected %02h/%0b",
                     exp_tag, rx_byte, rx_parity_err, exp_item[7:0], exp_item[8]);
          end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h, expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_rs(string tag);
    check(got_rs == exp_rs, tag, got_rs, exp_rs);
  endtask

  task automatic expect_byte(logic [7:0] b, bit perr, string tag);
    sb.push_back({perr, b});
    tq.push_back(tag);
  endtask

  task automatic wait_us(int n);
    repeat (n) @(posedge us_tick);
  endtask

  // Device-side frame: data set while clock high, then 40 us low, 40 us high.
  task automatic drive_frame(logic [7:0] b, bit flip_par, bit start_v, bit stop_v,
                             int n_edges, bit glitch, bit align_ready);
    logic [10:0] bits;
    bits = {stop_v, (~^b) ^ flip_par, b, start_v};
    for (int i = 0; i < n_edges; i++) begin
      ps2_dat_in = bits[i];
      wait_us(40);
      ps2_clk_in = 1'b0;
      if (align_ready && i == 10) begin
        // Byte reaches the slot on the 4th clock edge after the pad falls.
        repeat (3) @(negedge clk);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
      end
      if (glitch && i == 4) begin
        wait_us(10);
        ps2_clk_in = 1'b1;
        wait_us(1);
        ps2_clk_in = 1'b0;
        wait_us(29);
      end else begin
        wait_us(40);
      end
      ps2_clk_in = 1'b1;
    end
    ps2_dat_in = 1'b1;
    wait_us(100);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
    check(resend_req == 1'b0, "R11 resend_req", resend_req, 0);
    check(resend_cmd == 8'hFE, "R11 resend_cmd", resend_cmd, 8'hFE);
    rst_n = 1'b1;
    wait_us(150);

    // R1: plain bytes, write path off
    expect_byte(8'h00, 0, "R1"); drive_frame(8'h00, 0, 0, 1, 11, 0, 0);
    expect_byte(8'hFF, 0, "R1"); drive_frame(8'hFF, 0, 0, 1, 11, 0, 0);
    expect_byte(8'hA5, 0, "R1"); drive_frame(8'hA5, 0, 0, 1, 11, 0, 0);
    expect_byte(8'h3C, 0, "R1"); drive_frame(8'h3C, 0, 0, 1, 11, 0, 0);
    expect_byte(8'h81, 0, "R1"); drive_frame(8'h81, 0, 0, 1, 11, 0, 0);
    check_rs("R1 no resend");

    // R5: acknowledge dropped, not-acknowledge faults
    drive_frame(8'hFA, 0, 0, 1, 11, 0, 0);
    check_rs("R5 ack dropped");
    check(sb.size() == 0, "R5 queue", sb.size(), 0);
    exp_rs++; drive_frame(8'hFE, 0, 0, 1, 11, 0, 0);
    check_rs("R5 nack resend");

    // R4: parity fault fatal with write path off
    exp_rs++; drive_frame(8'h12, 1, 0, 1, 10, 0, 0);
    check_rs("R4 parity fatal");

    // R2: bad start
    exp_rs++; drive_frame(8'h00, 0, 1, 1, 1, 0, 0);
    check_rs("R2 bad start");

    // R3: bad stop
    exp_rs++; drive_frame(8'h34, 0, 0, 0, 11, 0, 0);
    check_rs("R3 bad stop");

    // R7: partial frame then silence
    exp_rs++; drive_frame(8'h56, 0, 0, 1, 4, 0, 0);
    check_rs("R7 timeout");
    expect_byte(8'h9C, 0, "R7 recover"); drive_frame(8'h9C, 0, 0, 1, 11, 0, 0);
    wait_us(300);
    check_rs("R7 idle gap");

    // R6: glitch edge inside a bit
    expect_byte(8'h6B, 0, "R6"); drive_frame(8'h6B, 0, 0, 1, 11, 1, 0);
    check_rs("R6 glitch ignored");

    // R8: edge right after a transmit completes
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    wait_us(10);
    ps2_dat_in = 1'b0; ps2_clk_in = 1'b0;
    wait_us(2);
    ps2_clk_in = 1'b1; ps2_dat_in = 1'b1;
    wait_us(20);
    expect_byte(8'hC3, 0, "R8"); drive_frame(8'hC3, 0, 0, 1, 11, 0, 0);
    check_rs("R8 spurious ignored");

    // Write path on: R5 codes delivered, R4 parity flagged
    wr_en_cfg = 1'b1;
    expect_byte(8'hFA, 0, "R5 ack kept"); drive_frame(8'hFA, 0, 0, 1, 11, 0, 0);
    expect_byte(8'hFE, 0, "R5 nack kept"); drive_frame(8'hFE, 0, 0, 1, 11, 0, 0);
    expect_byte(8'h77, 1, "R4 perr flag"); drive_frame(8'h77, 1, 0, 1, 11, 0, 0);
    check_rs("R4 R5 no resend");

    // R9: blocked slot
    rx_ready = 1'b0;
    expect_byte(8'h11, 0, "R9"); drive_frame(8'h11, 0, 0, 1, 11, 0, 0);
    check(rx_valid && rx_byte == 8'h11, "R9 held", rx_byte, 8'h11);
    exp_rs++; drive_frame(8'h22, 0, 0, 1, 11, 0, 0);
    check(rx_valid && rx_byte == 8'h11, "R9 not overwritten", rx_byte, 8'h11);
    check_rs("R9 overflow resend");
    @(negedge clk); rx_ready = 1'b1;
    wait_us(2);

    // R10: completion and acceptance in the same cycle
    @(negedge clk); rx_ready = 1'b0;
    expect_byte(8'h44, 0, "R10 first"); drive_frame(8'h44, 0, 0, 1, 11, 0, 0);
    expect_byte(8'h55, 0, "R10 second"); drive_frame(8'h55, 0, 0, 1, 11, 0, 1);
    check(rx_valid && rx_byte == 8'h55, "R10 loaded", rx_byte, 8'h55);
    check_rs("R10 no resend");
    @(negedge clk); rx_ready = 1'b1;
    wait_us(2);

    check(sb.size() == 0, "R1 all delivered", sb.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual hung, expected finished");
      summary();
      $finish;
    end
  end
endmodule